// File: doc/BRIEF.md
# Set-Associative Tag Array with Per-Set Rotating Victim Choice

This block holds the tag side of a set-associative cache. No data bytes are kept. Each line records a valid flag, a dirty flag and a tag. The block cuts each 32-bit request address into three fields. The low bits pick a byte inside the block. The middle bits choose a set. The high bits are the tag, which is compared against every way of the chosen set. All responses are combinational from the request and the stored state, so a parent controller reads them in the same cycle it presents a request. The state changes at the next clock edge.

A parent controller uses four operations: lookup, insert, invalidate and mark-dirty. On insert, the block picks the way itself. The first choice is the lowest-numbered free way. When the set is full, the way comes from a wrapping counter kept for that set. The line pushed out is reported with its block address and dirty flag, so the controller can send it onward before it is overwritten. Block size, way count and set count are power-of-two parameters (defaults: 8-byte blocks, 4 ways, 16 sets).

Top module: `rr_tag_array`

## Requirements
- R1: The byte offset is `req_addr[2:0]` and has no effect on matching. The set index is `req_addr[6:3]`. The tag is `req_addr[31:7]`. The same tag under another index does not match.
- R2: With `req_valid` high, `hit` is 1 in the same cycle when any valid way of the indexed set holds the tag. `hit_way` then gives the lowest such way. Operation codes on `req_op` are 0 lookup, 1 insert, 2 invalidate, 3 mark-dirty.
- R3: After reset, every line is invalid and clean and every set counter is 0. All lookups miss, and the first fill of a set goes to way 0.
- R4: An insert into a set with a free way writes into the lowest-numbered free way. It reports that way on `fill_way`, keeps `victim_valid` low, and the inserted tag hits from the next cycle.
- R5: An insert into a full set targets the way named by that set's counter. It raises `victim_valid` and reports the old line as `victim_addr` = {old tag, index, 3'b000} together with its dirty flag. The new tag then replaces the old line.
- R6: A set's counter steps by one only on an eviction in that set and wraps from 3 to 0. Fills into free ways, and activity in other sets, leave it unchanged.
- R7: Invalidate clears the valid and dirty flags of way `req_way` in the indexed set. The old tag then misses, and a later insert refills that way without a victim.
- R8: Mark-dirty sets the dirty flag of way `req_way` in the indexed set when that line is valid. On an invalid line it is ignored, and the line stays invalid and keeps missing.
- R9: The dirty flag given with an insert (`req_dirty`) is stored, and it is the value reported in `victim_dirty` when that line is later evicted.
- R10: While `req_valid` is low, `hit` and `victim_valid` stay 0 and no stored state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 lookup, 1 insert, 2 invalidate, 3 mark-dirty |
| req_addr | input | 32 | Byte address of the request |
| req_dirty | input | 1 | Dirty flag stored by an insert |
| req_way | input | 2 | Way targeted by invalidate and mark-dirty |
| hit | output | 1 | Tag found in a valid way of the indexed set |
| hit_way | output | 2 | Lowest way that matched |
| fill_way | output | 2 | Way an insert writes |
| victim_valid | output | 1 | The insert displaces a valid line |
| victim_addr | output | 32 | Block address of the displaced line |
| victim_dirty | output | 1 | Dirty flag of the displaced line |

## Verification
Most internal state cannot be seen directly at the ports. A wrong valid or tag bit shows up on the next lookup of that set as a false hit or a false miss. A wrong dirty flag, or a counter that steps at the wrong time, stays hidden until the set is full and the next insert evicts a line. At that point `fill_way`, `victim_addr` or `victim_dirty` differ from the expected values. A request stream that keeps a few sets full, and returns to them often, turns these latent faults into port mismatches within a few operations.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP   = 2'd0,
    OP_INSERT   = 2'd1,
    OP_INVAL    = 2'd2,
    OP_SETDIRTY = 2'd3
  } ts_op_e;
endpackage

// File: rtl/ts_addr_split.sv
module ts_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 25
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  blk_tag,
  input  logic [IDX_W-1:0]  blk_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] blk_addr
);
  assign tag = addr[ADDR_W-1 -: TAG_W];

  generate
    if (SETS > 1) begin : g_indexed
      assign idx = addr[OFF_W +: IDX_W];
      always_comb begin
        blk_addr = '0;
        blk_addr[ADDR_W-1 -: TAG_W] = blk_tag;
        blk_addr[OFF_W +: IDX_W]    = blk_idx;
      end
    end else begin : g_single_set
      assign idx = '0;
      always_comb begin
        blk_addr = '0;
        blk_addr[ADDR_W-1 -: TAG_W] = blk_tag;
      end
    end
  endgenerate
endmodule

// File: rtl/ts_way_pick.sv
module ts_way_pick #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 25,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       match_any,
  output logic [WAY_W-1:0]           match_way,
  output logic                       free_any,
  output logic [WAY_W-1:0]           free_way
);
  logic [WAYS-1:0] match_vec;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match_vec[w] = row_valid[w] && (row_tag[w] == look_tag);
    end
  endgenerate

  always_comb begin
    match_way = '0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w])  match_way = WAY_W'(w);
      if (!row_valid[w]) free_way  = WAY_W'(w);
    end
  end

  assign match_any = |match_vec;
  assign free_any  = ~&row_valid;
endmodule

// File: rtl/ts_rr_bank.sv
module ts_rr_bank #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             advance,
  output logic [WAY_W-1:0] cur_way
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic [WAY_W-1:0]           ptr_step;

  assign cur_way  = ptr_q[sel_idx];

  always_comb begin
    if (cur_way == LAST_WAY) ptr_step = '0;
    else                     ptr_step = cur_way + WAY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q[sel_idx] <= ptr_step;
    end
  end

  AST_RR_STEPS_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr_q[$past(sel_idx)] ==
                 (($past(cur_way) == LAST_WAY) ? '0 : $past(cur_way) + WAY_W'(1)))); // R6

  AST_RR_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/rr_tag_array.sv
module rr_tag_array
  import tagstore_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 8,
  parameter int WAYS        = 4,
  parameter int SETS        = 16,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int IDX_BITS   = $clog2(SETS),
  localparam int IDX_W      = (SETS > 1) ? IDX_BITS : 1,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dirty,
  input  logic [WAY_W-1:0]  req_way,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [WAY_W-1:0]  fill_way,
  output logic              victim_valid,
  output logic [ADDR_W-1:0] victim_addr,
  output logic              victim_dirty
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // line state
  logic [SETS-1:0][WAYS-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];

  ts_op_e                    op;
  logic [TAG_W-1:0]          req_tag;
  logic [IDX_W-1:0]          idx;
  logic [WAYS-1:0]           row_valid, row_dirty;
  logic [WAYS-1:0][TAG_W-1:0] row_tag;
  logic                      match_any, free_any;
  logic [WAY_W-1:0]          match_way, free_way, rr_way;
  logic                      do_insert, do_inval, do_mark, row_we, evict;
  logic [WAYS-1:0]           row_valid_d, row_dirty_d, tag_we;

  assign op = ts_op_e'(req_op);

  ts_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .addr    (req_addr),
    .blk_tag (row_tag[fill_way]),
    .blk_idx (idx),
    .tag     (req_tag),
    .idx     (idx),
    .blk_addr(victim_addr)
  );

  always_comb begin
    row_valid = valid_q[idx];
    row_dirty = dirty_q[idx];
    for (int w = 0; w < WAYS; w++) row_tag[w] = tag_q[idx][w];
  end

  ts_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_pick (
    .row_valid(row_valid),
    .row_tag  (row_tag),
    .look_tag (req_tag),
    .match_any(match_any),
    .match_way(match_way),
    .free_any (free_any),
    .free_way (free_way)
  );

  assign do_insert = req_valid && (op == OP_INSERT);
  assign do_inval  = req_valid && (op == OP_INVAL);
  assign do_mark   = req_valid && (op == OP_SETDIRTY);
  assign row_we    = do_insert || do_inval || do_mark;
  assign evict     = do_insert && !free_any;

  ts_rr_bank #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .sel_idx(idx),
    .advance(evict),
    .cur_way(rr_way)
  );

  // responses
  assign hit          = req_valid && match_any;
  assign hit_way      = match_way;
  assign fill_way     = free_any ? free_way : rr_way;
  assign victim_valid = evict;
  assign victim_dirty = evict && row_dirty[fill_way];

  // next state of the addressed row
  always_comb begin
    row_valid_d = row_valid;
    row_dirty_d = row_dirty;
    tag_we      = '0;
    if (do_insert) begin
      row_valid_d[fill_way] = 1'b1;
      row_dirty_d[fill_way] = req_dirty;
      tag_we[fill_way]      = 1'b1;
    end else if (do_inval) begin
      row_valid_d[req_way] = 1'b0;
      row_dirty_d[req_way] = 1'b0;
    end else if (do_mark && row_valid[req_way]) begin
      row_dirty_d[req_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (row_we) begin
      valid_q[idx] <= row_valid_d;
      dirty_q[idx] <= row_dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_insert) begin
      for (int w = 0; w < WAYS; w++) begin
        if (tag_we[w]) tag_q[idx][w] <= req_tag;
      end
    end
  end

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n_i)
    do_insert |=> (valid_q[$past(idx)][$past(fill_way)] &&
                   tag_q[$past(idx)][$past(fill_way)] == $past(req_tag))); // R4

  AST_INSERT_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n_i)
    do_insert |=> (dirty_q[$past(idx)][$past(fill_way)] == $past(req_dirty))); // R9

  AST_VICTIM_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n_i)
    victim_valid |-> (&valid_q[idx])); // R5

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_i)
    do_inval |=> (!valid_q[$past(idx)][$past(req_way)] &&
                  !dirty_q[$past(idx)][$past(req_way)])); // R7

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((dirty_q[idx] & ~valid_q[idx]) == '0)); // R8

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
    !req_valid |=> ($stable(valid_q) && $stable(dirty_q))); // R10
endmodule

// File: tb/sim_rr_tag_array.sv
`timescale 1ns/1ps
module sim_rr_tag_array;
  localparam int NW = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic        req_dirty;
  logic [1:0]  req_way;
  logic        hit;
  logic [1:0]  hit_way, fill_way;
  logic        victim_valid, victim_dirty;
  logic [31:0] victim_addr;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference state
  bit          mv [NS][NW];
  bit          md [NS][NW];
  int unsigned mt [NS][NW];
  int          mrr[NS];

  always #10 clk = ~clk;

  rr_tag_array u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_dirty(req_dirty), .req_way(req_way),
    .hit(hit), .hit_way(hit_way), .fill_way(fill_way),
    .victim_valid(victim_valid), .victim_addr(victim_addr), .victim_dirty(victim_dirty)
  );

  function automatic logic [31:0] mk(int unsigned tg, int ix, int off);
    return (32'(tg) << 7) | (32'(ix) << 3) | 32'(off);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic op(string req, bit v, int o, logic [31:0] a, bit d, int w);
    int ix, ehw, free, fw;
    int unsigned tg;
    bit eh, ev;
    @(negedge clk);
    req_valid = v; req_op = 2'(o); req_addr = a; req_dirty = d; req_way = 2'(w);
    #2;
    ix = int'((a >> 3) & 32'hF);
    tg = a >> 7;
    eh = 0; ehw = 0; free = -1;
    for (int k = NW - 1; k >= 0; k--) begin
      if (mv[ix][k] && mt[ix][k] == tg) begin eh = 1; ehw = k; end
      if (!mv[ix][k]) free = k;
    end
    chk(req, "hit", hit, v && eh);
    if (v && eh) chk(req, "hit_way", hit_way, ehw);
    ev = v && (o == 1) && (free < 0);
    chk(req, "victim_valid", victim_valid, ev);
    fw = (free >= 0) ? free : mrr[ix];
    if (v && o == 1) chk(req, "fill_way", fill_way, fw);
    if (ev) begin
      chk(req, "victim_addr", victim_addr, mk(mt[ix][fw], ix, 0));
      chk(req, "victim_dirty", victim_dirty, md[ix][fw]);
    end
    @(posedge clk);
    if (v) begin
      case (o)
        1: begin
          if (ev) mrr[ix] = (mrr[ix] + 1) % NW;
          mv[ix][fw] = 1; md[ix][fw] = d; mt[ix][fw] = tg;
        end
        2: begin mv[ix][w] = 0; md[ix][w] = 0; end
        3: if (mv[ix][w]) md[ix][w] = 1;
        default: ;
      endcase
    end
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_dirty = 1'b0; req_way = '0;
    do_reset();

    // R3: everything empty after reset
    op("R3", 1, 0, mk(0, 0, 0), 0, 0);
    op("R3", 1, 0, mk(0, 2, 0), 0, 0);
    op("R3", 1, 0, mk(5, 15, 7), 0, 0);

    // R4: lowest free way fills first
    for (int k = 0; k < 4; k++) op("R4", 1, 1, mk(10 + k, 2, 0), k[0], 0);

    // R1: offset ignored, index participates
    op("R1", 1, 0, mk(11, 2, 5), 0, 0);
    op("R1", 1, 0, mk(11, 3, 5), 0, 0);
    op("R1", 1, 0, mk(13, 2, 7), 0, 0);

    // R5: full set evicts counter way with address and dirty flag
    op("R5", 1, 1, mk(20, 2, 3), 0, 0);

    // R6: counter rotates and wraps
    for (int k = 0; k < 4; k++) op("R6", 1, 1, mk(21 + k, 2, 0), 0, 0);

    // R6: another set keeps its own counter
    for (int k = 0; k < 5; k++) op("R6", 1, 1, mk(40 + k, 5, 0), 1, 0);

    // R7: invalidate, then miss, then refill without victim
    op("R7", 1, 2, mk(0, 2, 0), 0, 2);
    op("R7", 1, 0, mk(22, 2, 0), 0, 0);
    op("R7", 1, 1, mk(30, 2, 0), 0, 0);
    op("R6", 1, 1, mk(31, 2, 0), 0, 0);

    // R8: mark-dirty on a valid line, ignored on an invalid one
    op("R8", 1, 3, mk(0, 2, 0), 0, 3);
    op("R8", 1, 2, mk(0, 5, 0), 0, 1);
    op("R8", 1, 3, mk(0, 5, 0), 0, 1);
    op("R8", 1, 0, mk(41, 5, 0), 0, 0);
    op("R8", 1, 1, mk(50, 5, 0), 0, 0);

    // R9: evictions report stored dirty flags
    for (int k = 0; k < 5; k++) op("R9", 1, 1, mk(60 + k, 2, 0), 0, 0);

    // R10: requests without req_valid change nothing
    op("R10", 0, 1, mk(70, 7, 0), 1, 0);
    op("R10", 0, 2, mk(62, 2, 0), 0, 0);
    op("R10", 1, 0, mk(70, 7, 0), 0, 0);
    op("R10", 1, 0, mk(62, 2, 0), 0, 0);

    // R2: mixed traffic on a few crowded sets
    for (int k = 0; k < 4000; k++) begin
      int o, ix, tg, w;
      bit v;
      v  = ($urandom_range(0, 9) != 0);
      o  = $urandom_range(0, 9);
      o  = (o < 4) ? 0 : (o < 7) ? 1 : (o < 8) ? 2 : 3;
      ix = $urandom_range(0, 3);
      tg = $urandom_range(0, 6);
      w  = $urandom_range(0, 3);
      op("R2", v, o, mk(tg, ix, $urandom_range(0, 7)), 1'($urandom_range(0, 1)), w);
    end

    // R3: a second reset empties the array and counters
    do_reset();
    op("R3", 1, 0, mk(3, 1, 0), 0, 0);
    for (int k = 0; k < 6; k++) op("R3", 1, 1, mk(80 + k, 2, 0), 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule